// File: doc/BRIEF.md
# Multi-channel gamma lookup table

This block applies a per-channel colour-correction curve to an RGB pixel stream, one pixel per clock. The curves of every display channel sit in one flat storage array. Each channel owns three back-to-back tables of 256 entries, and each entry holds an 8-bit output value.

Software fills the array through two write strobes. The first loads an address pointer together with a step flag. The second stores a data byte at the pointer. With the step flag set, the pointer moves forward by one after every byte, so a complete channel curve goes in as one stream of 768 bytes.

On the pixel side, a pixel tagged with a channel number is looked up in that channel's three tables. The result appears two clocks later, with its valid flag delayed by the same amount. A per-channel enable decides whether the corrected value or the original pixel is sent out.

Top module: `gamma_lut`

## Requirements
- R1: After reset, every entry holds its own index within its table. A pixel sent through an enabled channel that has not been loaded comes out equal to the input.
- R2: The flat address of an entry is chan*768 + colour*256 + index, where colour 0 is red, 1 is green and 2 is blue. A pixel component reads its own entry at that address.
- R3: A pointer load with the step flag set (cfg_autoinc=1), followed by data writes, stores the bytes at consecutive flat addresses starting from the loaded value.
- R4: With the step flag clear, every data write goes to the same address. The last byte written wins, and the neighbouring entries keep their contents.
- R5: When stepping, the pointer goes from the last entry (NUM_CH*768-1, which is 2303 for 3 channels) back to address 0.
- R6: When the gamma_en bit of the pixel's channel is 0, the output equals the input, whatever the table holds.
- R7: out_valid goes high exactly two clocks after pix_valid, for one clock for each input pixel, and carries the result of that pixel.
- R8: A data write and a pixel lookup of the same entry in the same clock make the lookup return the entry's old contents. The next lookup of that entry returns the new byte.
- R9: A pixel whose channel number is NUM_CH or above passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_wr | input | 1 | Load the address pointer and the step flag |
| cfg_addr_wdata | input | AW (12) | New pointer value |
| cfg_autoinc | input | 1 | Step flag stored with the pointer |
| cfg_data_wr | input | 1 | Store cfg_data_wdata at the pointer |
| cfg_data_wdata | input | DW (8) | Table byte |
| gamma_en | input | NUM_CH (3) | Per-channel correction enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_chan | input | CW (2) | Channel of the input pixel |
| pix_r | input | DW (8) | Red component in |
| pix_g | input | DW (8) | Green component in |
| pix_b | input | DW (8) | Blue component in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | DW (8) | Red component out |
| out_g | output | DW (8) | Green component out |
| out_b | output | DW (8) | Blue component out |

## Verification
A table write from the load port and a pixel lookup can land in the same clock and on the same entry. The bench provokes this by raising cfg_data_wr and pix_valid on the same edge, with the pointer resting on the green entry that the pixel addresses. The output of that pixel must show the entry's old contents. A second pixel sent straight afterwards must show the new byte, which proves that the write happened and only the ordering was judged.

// File: rtl/glut_pkg.sv
package glut_pkg;
   localparam int NCOL = 3;

   // identity content of a flat address: its index inside its table
   function automatic int ident_value(input int flat_addr, input int entries);
      return flat_addr % entries;
   endfunction
endpackage

// File: rtl/glut_addr_ctrl.sv
module glut_addr_ctrl #(
   parameter int AW    = 12,
   parameter int TOTAL = 2304
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_wr,
   input  logic [AW-1:0] addr_val,
   input  logic          autoinc,
   input  logic          data_wr,
   output logic [AW-1:0] wr_addr
);
   localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

   logic [AW-1:0] addr_q;
   logic          inc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         inc_q  <= 1'b0;
      end else if (addr_wr) begin
         addr_q <= addr_val;
         inc_q  <= autoinc;
      end else if (data_wr && inc_q) begin
         addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
      end
   end

   assign wr_addr = addr_q;

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && inc_q && !addr_wr && addr_q < LAST) |=> (addr_q == $past(addr_q) + 1'b1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !inc_q && !addr_wr) |=> $stable(addr_q));

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && inc_q && !addr_wr && addr_q == LAST) |=> (addr_q == '0));
endmodule

// File: rtl/glut_ram.sv
module glut_ram #(
   parameter int AW      = 12,
   parameter int DW      = 8,
   parameter int TOTAL   = 2304,
   parameter int ENTRIES = 256,
   parameter int NPORT   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [AW-1:0]              waddr,
   input  logic [DW-1:0]              wdata,
   input  logic [NPORT-1:0][AW-1:0]   raddr,
   output logic [NPORT-1:0][DW-1:0]   rdata
);
   import glut_pkg::*;

   localparam logic [AW:0] LIMIT = (AW+1)'(TOTAL);

   if (TOTAL > (2 ** AW)) begin : g_bad_aw
      $error("glut_ram: AW too narrow for TOTAL");
   end

   logic [DW-1:0] mem [TOTAL];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TOTAL; i++) begin
            mem[i] <= DW'(ident_value(i, ENTRIES));
         end
      end else if (we && ({1'b0, waddr} < LIMIT)) begin
         mem[waddr] <= wdata;
      end
   end

   // one registered read port per colour; a same-edge write is not seen
   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if ({1'b0, raddr[p]} < LIMIT) q <= mem[raddr[p]];
         else                          q <= '0;
      end
      assign rdata[p] = q;
   end
endmodule

// File: rtl/glut_pipe.sv
module glut_pipe #(
   parameter int DW   = 8,
   parameter int NCOL = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_en,
   input  logic [NCOL-1:0][DW-1:0]  in_pix,
   input  logic [NCOL-1:0][DW-1:0]  lut_pix,
   output logic                     out_valid,
   output logic [NCOL-1:0][DW-1:0]  out_pix
);
   logic                    s1_valid, s1_en;
   logic [NCOL-1:0][DW-1:0] s1_pix;
   logic                    o_valid;
   logic [NCOL-1:0][DW-1:0] o_pix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_en    <= 1'b0;
         s1_pix   <= '0;
         o_valid  <= 1'b0;
         o_pix    <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_en    <= in_en;
         s1_pix   <= in_pix;
         o_valid  <= s1_valid;
         o_pix    <= s1_en ? lut_pix : s1_pix;
      end
   end

   assign out_valid = o_valid;
   assign out_pix   = o_pix;

   p_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);

   p_nolat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);

   p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_en) |=> (out_pix == $past(s1_pix)));

   p_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_en) |=> (out_pix == $past(lut_pix)));
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut #(
   parameter int NUM_CH  = 3,
   parameter int DW      = 8,
   parameter int ENTRIES = 256,
   localparam int TOTAL  = NUM_CH * glut_pkg::NCOL * ENTRIES,
   localparam int AW     = $clog2(TOTAL),
   localparam int CW     = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_addr_wr,
   input  logic [AW-1:0]     cfg_addr_wdata,
   input  logic              cfg_autoinc,
   input  logic              cfg_data_wr,
   input  logic [DW-1:0]     cfg_data_wdata,
   input  logic [NUM_CH-1:0] gamma_en,
   input  logic              pix_valid,
   input  logic [CW-1:0]     pix_chan,
   input  logic [DW-1:0]     pix_r,
   input  logic [DW-1:0]     pix_g,
   input  logic [DW-1:0]     pix_b,
   output logic              out_valid,
   output logic [DW-1:0]     out_r,
   output logic [DW-1:0]     out_g,
   output logic [DW-1:0]     out_b
);
   import glut_pkg::*;

   localparam int CH_SPAN = NCOL * ENTRIES;

   if (ENTRIES != (2 ** DW)) begin : g_bad_entries
      $error("gamma_lut: ENTRIES must equal 2**DW");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("gamma_lut: NUM_CH must be at least 1");
   end

   logic [AW-1:0]             wr_addr;
   logic [NCOL-1:0][DW-1:0]   in_pix, lut_pix, o_pix;
   logic [NCOL-1:0][AW-1:0]   rd_addr;
   logic                      chan_ok, en_sel;

   assign in_pix[0] = pix_r;
   assign in_pix[1] = pix_g;
   assign in_pix[2] = pix_b;

   assign chan_ok = (int'(pix_chan) < NUM_CH);
   assign en_sel  = chan_ok && gamma_en[pix_chan];

   for (genvar c = 0; c < NCOL; c++) begin : g_addr
      assign rd_addr[c] = AW'(int'(pix_chan) * CH_SPAN + c * ENTRIES + int'(in_pix[c]));
   end

   glut_addr_ctrl #(.AW(AW), .TOTAL(TOTAL)) i_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_wr  (cfg_addr_wr),
      .addr_val (cfg_addr_wdata),
      .autoinc  (cfg_autoinc),
      .data_wr  (cfg_data_wr),
      .wr_addr  (wr_addr)
   );

   glut_ram #(.AW(AW), .DW(DW), .TOTAL(TOTAL), .ENTRIES(ENTRIES), .NPORT(NCOL)) i_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_data_wr),
      .waddr (wr_addr),
      .wdata (cfg_data_wdata),
      .raddr (rd_addr),
      .rdata (lut_pix)
   );

   glut_pipe #(.DW(DW), .NCOL(NCOL)) i_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pix_valid),
      .in_en     (en_sel),
      .in_pix    (in_pix),
      .lut_pix   (lut_pix),
      .out_valid (out_valid),
      .out_pix   (o_pix)
   );

   assign out_r = o_pix[0];
   assign out_g = o_pix[1];
   assign out_b = o_pix[2];
endmodule

// File: tb/test_gamma_lut.sv
module test_gamma_lut;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_addr_wr = 1'b0;
   logic [11:0] cfg_addr_wdata = '0;
   logic        cfg_autoinc = 1'b0;
   logic        cfg_data_wr = 1'b0;
   logic [7:0]  cfg_data_wdata = '0;
   logic [2:0]  gamma_en = 3'b111;
   logic        pix_valid = 1'b0;
   logic [1:0]  pix_chan = '0;
   logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
   logic        out_valid;
   logic [7:0]  out_r, out_g, out_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [7:0] got_r, got_g, got_b;

   always #5 clk = ~clk;

   gamma_lut i_gamma_lut (
      .clk(clk), .rst_n(rst_n),
      .cfg_addr_wr(cfg_addr_wr), .cfg_addr_wdata(cfg_addr_wdata), .cfg_autoinc(cfg_autoinc),
      .cfg_data_wr(cfg_data_wr), .cfg_data_wdata(cfg_data_wdata),
      .gamma_en(gamma_en), .pix_valid(pix_valid), .pix_chan(pix_chan),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   typedef struct packed {
      logic [1:0] ch;
      logic [2:0] en;
      logic [7:0] r, g, b;
      logic [7:0] er, eg, eb;
      logic [3:0] tag;
   } vec_t;

   // tag: 1=R1 identity, 2=R2/R3 loaded curve, 6=R6 disabled, 9=R9 bad channel
   localparam vec_t VECS [6] = '{
      '{2'd0, 3'b111, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56, 4'd1},
      '{2'd1, 3'b111, 8'h10, 8'h20, 8'h30, 8'hEF, 8'h7A, 8'h33, 4'd2},
      '{2'd1, 3'b111, 8'h00, 8'hFF, 8'hFD, 8'hFF, 8'hA5, 8'h00, 4'd2},
      '{2'd1, 3'b101, 8'h10, 8'h20, 8'h30, 8'h10, 8'h20, 8'h30, 4'd6},
      '{2'd2, 3'b111, 8'hAA, 8'hBB, 8'hCC, 8'hAA, 8'hBB, 8'hCC, 4'd1},
      '{2'd3, 3'b111, 8'h55, 8'h66, 8'h77, 8'h55, 8'h66, 8'h77, 4'd9}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_addr(input logic [11:0] a, input logic inc);
      @(negedge clk);
      cfg_addr_wr = 1'b1; cfg_addr_wdata = a; cfg_autoinc = inc;
      @(negedge clk);
      cfg_addr_wr = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] d);
      @(negedge clk);
      cfg_data_wr = 1'b1; cfg_data_wdata = d;
      @(negedge clk);
      cfg_data_wr = 1'b0;
   endtask

   // present one pixel, check the two-clock latency, capture the result
   task automatic send_pix(input logic [1:0] ch, input logic [7:0] r, g, b);
      @(negedge clk);
      pix_valid = 1'b1; pix_chan = ch; pix_r = r; pix_g = g; pix_b = b;
      @(negedge clk);
      pix_valid = 1'b0;
      check("R7 valid low after one clock", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      check("R7 valid high after two clocks", {31'd0, out_valid}, 32'd1);
      got_r = out_r; got_g = out_g; got_b = out_b;
      @(negedge clk);
      check("R7 valid single cycle", {31'd0, out_valid}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 reset out_valid", {31'd0, out_valid}, 32'd0);

      // R3: stream channel 1 curves: red 255-i, green i^5A, blue i+3
      set_addr(12'd768, 1'b1);
      for (int i = 0; i < 768; i++) begin
         logic [7:0] idx;
         idx = 8'(i % 256);
         if (i < 256)      wr_data(8'hFF - idx);
         else if (i < 512) wr_data(idx ^ 8'h5A);
         else              wr_data(idx + 8'd3);
      end

      for (int v = 0; v < 6; v++) begin
         string req;
         case (VECS[v].tag)
            4'd1:    req = "R1 identity";
            4'd2:    req = "R2 R3 loaded curve";
            4'd6:    req = "R6 disabled passthrough";
            default: req = "R9 bad channel passthrough";
         endcase
         gamma_en = VECS[v].en;
         send_pix(VECS[v].ch, VECS[v].r, VECS[v].g, VECS[v].b);
         check({req, " red"},   {24'd0, got_r}, {24'd0, VECS[v].er});
         check({req, " green"}, {24'd0, got_g}, {24'd0, VECS[v].eg});
         check({req, " blue"},  {24'd0, got_b}, {24'd0, VECS[v].eb});
      end
      gamma_en = 3'b111;

      // R4: fixed address, last write wins, neighbour untouched
      set_addr(12'd0, 1'b0);
      wr_data(8'h11);
      wr_data(8'h22);
      send_pix(2'd0, 8'h00, 8'h00, 8'h00);
      check("R4 last write wins", {24'd0, got_r}, 32'h22);
      send_pix(2'd0, 8'h01, 8'h00, 8'h00);
      check("R4 neighbour untouched", {24'd0, got_r}, 32'h01);

      // R5: step past the final entry wraps to 0
      set_addr(12'd2303, 1'b1);
      wr_data(8'h77);
      wr_data(8'h88);
      send_pix(2'd2, 8'h00, 8'h00, 8'hFF);
      check("R5 last entry written", {24'd0, got_b}, 32'h77);
      send_pix(2'd0, 8'h00, 8'h00, 8'h00);
      check("R5 wrapped to entry 0", {24'd0, got_r}, 32'h88);

      // R8: write and lookup of the same entry in one clock
      set_addr(12'd1797, 1'b0);
      @(negedge clk);
      cfg_data_wr = 1'b1; cfg_data_wdata = 8'h99;
      pix_valid = 1'b1; pix_chan = 2'd2; pix_r = 8'h00; pix_g = 8'h05; pix_b = 8'h00;
      @(negedge clk);
      cfg_data_wr = 1'b0; pix_valid = 1'b0;
      @(negedge clk);
      check("R8 collision valid", {31'd0, out_valid}, 32'd1);
      check("R8 collision returns old", {24'd0, out_g}, 32'h05);
      send_pix(2'd2, 8'h00, 8'h05, 8'h00);
      check("R8 next lookup sees new", {24'd0, got_g}, 32'h99);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule